// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks a DDR2 or DDR3 memory device through its power-up command sequence. The sequence starts on a one-cycle start pulse. At that pulse the block captures the device-type select and the geometry inputs. It then issues commands one at a time, each on a single-cycle valid strobe.

Consecutive strobes are separated by a fixed minimum gap. The long power-up wait and the DLL settling wait are longer and are counted from a cycles-per-microsecond parameter, so a simulation can use short counts. Extended mode-register loads carry a bank number in two forms: on its own port, and shifted to a bank-address bit position derived from the captured geometry.

Two mode-register control flags, DLL reset and OCD default, are driven alongside the commands that need them. After the final dummy write, a refresh-rate load strobe marks the hand-over to normal operation. A done flag then stays high.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: The bank bit offset is the column field plus 9. When the sequential decode flag is set, the row field plus 11 is added. Then 1 is added for a narrow bus or 2 for a full-width bus. An extended load (code 4) shows its bank on `bank_o` and `bank << offset` on `addr_o`. All other commands show 0 on both.
- R2: With `ddr3_i`=0, the commands come in this order: NOP(1), NOP(1), precharge-all(2), ext-load bank 2, ext-load bank 3, ext-load bank 1, mode load(3), precharge-all(2), refresh(5), refresh(5), mode load(3), ext-load bank 1, ext-load bank 1, normal(0), dummy write(7).
- R3: In DDR2 mode, `dll_rst_o` is 1 during the strobes from the first mode load through the second refresh. It is 0 at the second mode load. `ocd_dflt_o` is 1 only at the first of the two closing bank-1 ext-loads.
- R4: With `ddr3_i`=1, the commands come in this order: NOP, NOP, ext-load banks 2, 3, 1, mode load, calibrate(6), normal, dummy write. No precharge or refresh is issued, and both flags stay 0.
- R5: The spacing from the first NOP strobe to the second is GAP_CYC+1+200·CYC_PER_US cycles for DDR2, and GAP_CYC+1+500·CYC_PER_US cycles for DDR3.
- R6: In DDR3 mode, the spacing from the mode-load strobe to the calibrate strobe is GAP_CYC+1+50·CYC_PER_US cycles.
- R7: Each command strobe lasts exactly one cycle. All other consecutive strobes are GAP_CYC+1 cycles apart.
- R8: `rfsh_load_o` pulses for one cycle, GAP_CYC+1 cycles after the dummy-write strobe. `done_o` rises on the next cycle.
- R9: `done_o` stays high until the next start. A start pulse received while the sequence runs has no effect.
- R10: The device type and geometry are captured at start. Changes to them during the sequence have no effect.
- R11: After reset no strobe is active, and `done_o`, `rfsh_load_o` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| ddr3_i | input | 1 | Device type: 1 = DDR3, 0 = DDR2 |
| col_bits_i | input | COL_W | Column-bits field |
| row_bits_i | input | ROW_W | Row-bits field |
| seq_decode_i | input | 1 | Sequential address decode flag |
| narrow_bus_i | input | 1 | Narrow data-bus flag |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_o | output | 3 | Command code |
| bank_o | output | 2 | Bank number of an extended load |
| addr_o | output | ADDR_W | Bank placed at the computed bit offset |
| dll_rst_o | output | 1 | DLL reset flag |
| ocd_dflt_o | output | 1 | OCD default flag |
| rfsh_load_o | output | 1 | Refresh-rate load strobe |
| done_o | output | 1 | Sequence complete |

## Verification
The hardest case to reach from the ports is a start pulse or a geometry change that lands in the middle of a long power-up wait. At that point nothing is visible at the outputs that could reveal a restart or a re-captured offset. The bench raises start and scrambles every configuration input while the first wait is running. The scoreboard, filled from the values captured before the disturbance, then proves that the command order, addresses and spacing did not change. Three runs with different geometries cover offsets of 25, 12 and 10.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        CMD_NORMAL = 3'd0,
        CMD_NOP    = 3'd1,
        CMD_PRECH  = 3'd2,
        CMD_MRS    = 3'd3,
        CMD_EMRS   = 3'd4,
        CMD_RFSH   = 3'd5,
        CMD_CALIB  = 3'd6,
        CMD_WRITE  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        DLY_NONE,
        DLY_PWR,
        DLY_DLL
    } dly_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_LOAD,
        ST_DONE
    } state_e;

    typedef struct packed {
        cmd_e       cmd;
        logic [1:0] bank;
        logic       dll;
        logic       ocd;
        dly_e       dly;
        logic       last;
    } step_t;

    localparam int STEP_W = 4;

    function automatic step_t mk_step(input cmd_e c, input logic [1:0] b,
                                      input logic d, input logic o,
                                      input dly_e w, input logic l);
        step_t s;
        s.cmd  = c;
        s.bank = b;
        s.dll  = d;
        s.ocd  = o;
        s.dly  = w;
        s.last = l;
        return s;
    endfunction

    function automatic step_t step_lookup(input logic ddr3, input logic [STEP_W-1:0] idx);
        step_t s;
        s = mk_step(CMD_NOP, 2'd0, 1'b0, 1'b0, DLY_NONE, 1'b1);
        if (!ddr3) begin
            case (idx)
                4'd0:  s = mk_step(CMD_NOP,    2'd0, 1'b0, 1'b0, DLY_PWR,  1'b0);
                4'd1:  s = mk_step(CMD_NOP,    2'd0, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd2:  s = mk_step(CMD_PRECH,  2'd0, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd3:  s = mk_step(CMD_EMRS,   2'd2, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd4:  s = mk_step(CMD_EMRS,   2'd3, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd5:  s = mk_step(CMD_EMRS,   2'd1, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd6:  s = mk_step(CMD_MRS,    2'd0, 1'b1, 1'b0, DLY_NONE, 1'b0);
                4'd7:  s = mk_step(CMD_PRECH,  2'd0, 1'b1, 1'b0, DLY_NONE, 1'b0);
                4'd8:  s = mk_step(CMD_RFSH,   2'd0, 1'b1, 1'b0, DLY_NONE, 1'b0);
                4'd9:  s = mk_step(CMD_RFSH,   2'd0, 1'b1, 1'b0, DLY_NONE, 1'b0);
                4'd10: s = mk_step(CMD_MRS,    2'd0, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd11: s = mk_step(CMD_EMRS,   2'd1, 1'b0, 1'b1, DLY_NONE, 1'b0);
                4'd12: s = mk_step(CMD_EMRS,   2'd1, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd13: s = mk_step(CMD_NORMAL, 2'd0, 1'b0, 1'b0, DLY_NONE, 1'b0);
                default: s = mk_step(CMD_WRITE, 2'd0, 1'b0, 1'b0, DLY_NONE, 1'b1);
            endcase
        end else begin
            case (idx)
                4'd0:  s = mk_step(CMD_NOP,    2'd0, 1'b0, 1'b0, DLY_PWR,  1'b0);
                4'd1:  s = mk_step(CMD_NOP,    2'd0, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd2:  s = mk_step(CMD_EMRS,   2'd2, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd3:  s = mk_step(CMD_EMRS,   2'd3, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd4:  s = mk_step(CMD_EMRS,   2'd1, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd5:  s = mk_step(CMD_MRS,    2'd0, 1'b0, 1'b0, DLY_DLL,  1'b0);
                4'd6:  s = mk_step(CMD_CALIB,  2'd0, 1'b0, 1'b0, DLY_NONE, 1'b0);
                4'd7:  s = mk_step(CMD_NORMAL, 2'd0, 1'b0, 1'b0, DLY_NONE, 1'b0);
                default: s = mk_step(CMD_WRITE, 2'd0, 1'b0, 1'b0, DLY_NONE, 1'b1);
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/sdram_bank_offset.sv
module sdram_bank_offset #(
    parameter int COL_W = 2,
    parameter int ROW_W = 2,
    parameter int OFF_W = 5
) (
    input  logic [COL_W-1:0] col_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             seq_i,
    input  logic             narrow_i,
    output logic [OFF_W-1:0] offset_o
);
    logic [OFF_W-1:0] base, row_part, bus_part;

    always_comb begin
        base     = OFF_W'(col_i) + OFF_W'(9);
        row_part = seq_i ? (OFF_W'(row_i) + OFF_W'(11)) : '0;
        bus_part = narrow_i ? OFF_W'(1) : OFF_W'(2);
        offset_o = base + row_part + bus_part;
    end
endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = count_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == CNT_W'(1));

    // R7
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (count_i != '0));
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int COL_W      = 2,
    parameter int ROW_W      = 2,
    parameter int ADDR_W     = 32,
    parameter int CYC_PER_US = 4,
    parameter int GAP_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ddr3_i,
    input  logic [COL_W-1:0]  col_bits_i,
    input  logic [ROW_W-1:0]  row_bits_i,
    input  logic              seq_decode_i,
    input  logic              narrow_bus_i,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_o,
    output logic [1:0]        bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              dll_rst_o,
    output logic              ocd_dflt_o,
    output logic              rfsh_load_o,
    output logic              done_o
);
    localparam int OFF_MAX   = (2**COL_W - 1) + 9 + (2**ROW_W - 1) + 11 + 2;
    localparam int OFF_W     = $clog2(OFF_MAX + 1);
    localparam int WAIT_D2   = GAP_CYC + 200 * CYC_PER_US;
    localparam int WAIT_D3   = GAP_CYC + 500 * CYC_PER_US;
    localparam int WAIT_DLL  = GAP_CYC + 50 * CYC_PER_US;
    localparam int CNT_W     = $clog2(WAIT_D3 + 1);

    typedef struct packed {
        state_e            state;
        logic [STEP_W-1:0] step;
        logic              ddr3;
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic              seq;
        logic              narrow;
    } regs_t;

    regs_t            r_d, r_q;
    step_t            cur;
    logic [OFF_W-1:0] offset;
    logic             tmr_load, tmr_expire, busy;
    logic [CNT_W-1:0] tmr_count;

    sdram_bank_offset #(.COL_W(COL_W), .ROW_W(ROW_W), .OFF_W(OFF_W)) i_offset (
        .col_i    (r_q.col),
        .row_i    (r_q.row),
        .seq_i    (r_q.seq),
        .narrow_i (r_q.narrow),
        .offset_o (offset)
    );

    sdram_wait_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .count_i  (tmr_count),
        .expire_o (tmr_expire)
    );

    always_comb begin
        cur       = step_lookup(r_q.ddr3, r_q.step);
        tmr_load  = (r_q.state == ST_ISSUE);
        case (cur.dly)
            DLY_PWR: tmr_count = r_q.ddr3 ? CNT_W'(WAIT_D3) : CNT_W'(WAIT_D2);
            DLY_DLL: tmr_count = CNT_W'(WAIT_DLL);
            default: tmr_count = CNT_W'(GAP_CYC);
        endcase

        r_d = r_q;
        case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.state  = ST_ISSUE;
                    r_d.step   = '0;
                    r_d.ddr3   = ddr3_i;
                    r_d.col    = col_bits_i;
                    r_d.row    = row_bits_i;
                    r_d.seq    = seq_decode_i;
                    r_d.narrow = narrow_bus_i;
                end
            end
            ST_ISSUE: r_d.state = ST_WAIT;
            ST_WAIT: begin
                if (tmr_expire) begin
                    if (cur.last) begin
                        r_d.state = ST_LOAD;
                    end else begin
                        r_d.state = ST_ISSUE;
                        r_d.step  = r_q.step + 1'b1;
                    end
                end
            end
            ST_LOAD: r_d.state = ST_DONE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign busy        = (r_q.state == ST_ISSUE) || (r_q.state == ST_WAIT);
    assign cmd_valid_o = (r_q.state == ST_ISSUE);
    assign cmd_o       = cmd_valid_o ? cur.cmd : CMD_NOP;
    assign bank_o      = cmd_valid_o ? cur.bank : 2'd0;
    assign addr_o      = cmd_valid_o ? (ADDR_W'(cur.bank) << offset) : '0;
    assign dll_rst_o   = busy && cur.dll;
    assign ocd_dflt_o  = busy && cur.ocd;
    assign rfsh_load_o = (r_q.state == ST_LOAD);
    assign done_o      = (r_q.state == ST_DONE);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R4
    ddr3_no_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && r_q.ddr3) |-> (cmd_o != CMD_RFSH && cmd_o != CMD_PRECH));

    // R1
    emrs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == CMD_EMRS) |-> (bank_o != 2'd0 && addr_o != '0));

    // R3
    ocd_emrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && ocd_dflt_o) |-> (cmd_o == CMD_EMRS));

    // R8
    load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_load_o |=> (done_o && !rfsh_load_o));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> !done_o);
endmodule

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;
    localparam int COL_W = 2, ROW_W = 2, ADDR_W = 32, CPU = 4, GAP = 3;

    logic clk = 0, rst_n = 0, start_i = 0, ddr3_i = 0, seq_i = 0, narrow_i = 0;
    logic [COL_W-1:0] col_i = '0;
    logic [ROW_W-1:0] row_i = '0;
    logic cmd_valid_o, dll_rst_o, ocd_dflt_o, rfsh_load_o, done_o;
    logic [2:0] cmd_o;
    logic [1:0] bank_o;
    logic [ADDR_W-1:0] addr_o;

    int checks = 0, errors = 0, cyc = 0, last_cyc = 0, cur_off = 0;

    typedef struct {
        int     cmd;
        int     bank;
        longint addr;
        bit     dll;
        bit     ocd;
        int     delta;
        string  req;
    } item_t;
    item_t q[$];

    sdram_pwrup_seq #(.COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W),
                      .CYC_PER_US(CPU), .GAP_CYC(GAP)) i_sdram_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ddr3_i(ddr3_i),
        .col_bits_i(col_i), .row_bits_i(row_i), .seq_decode_i(seq_i),
        .narrow_bus_i(narrow_i), .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
        .bank_o(bank_o), .addr_o(addr_o), .dll_rst_o(dll_rst_o),
        .ocd_dflt_o(ocd_dflt_o), .rfsh_load_o(rfsh_load_o), .done_o(done_o));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int c, int b, bit d, bit o, int dl, string r);
        item_t it;
        it.cmd = c; it.bank = b; it.dll = d; it.ocd = o; it.delta = dl; it.req = r;
        it.addr = (c == 4) ? (longint'(b) << cur_off) : 0;
        q.push_back(it);
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (rst_n && (cmd_valid_o || rfsh_load_o)) begin
            if (q.size() == 0) begin
                check(0, "R9", "unexpected strobe cmd", cmd_o, -1);
            end else begin
                item_t e;
                e = q.pop_front();
                if (e.cmd == 8) begin
                    check(rfsh_load_o && !cmd_valid_o, "R8", "refresh load strobe", rfsh_load_o, 1);
                end else begin
                    check(cmd_valid_o && cmd_o == e.cmd[2:0], e.req, "command", cmd_o, e.cmd);
                    check(bank_o == e.bank[1:0], "R1", "bank", bank_o, e.bank);
                    check(longint'(addr_o) == e.addr, "R1", "addr", addr_o, e.addr);
                    check(dll_rst_o == e.dll && ocd_dflt_o == e.ocd, "R3", "flags dll,ocd",
                          {dll_rst_o, ocd_dflt_o}, {e.dll, e.ocd});
                end
                if (e.delta != 0)
                    check(cyc - last_cyc == e.delta, e.req, "strobe spacing", cyc - last_cyc, e.delta);
            end
            last_cyc = cyc;
        end
    end

    task automatic run_seq(bit d3, int col, int row, bit sq, bit nar, bit disturb);
        int g;
        g = GAP + 1;
        cur_off = col + 9 + (sq ? row + 11 : 0) + (nar ? 1 : 2);
        if (!d3) begin
            push(1, 0, 0, 0, 0, "R2");
            push(1, 0, 0, 0, g + 200 * CPU, "R5");
            push(2, 0, 0, 0, g, "R2");
            push(4, 2, 0, 0, g, "R2");
            push(4, 3, 0, 0, g, "R2");
            push(4, 1, 0, 0, g, "R2");
            push(3, 0, 1, 0, g, "R3");
            push(2, 0, 1, 0, g, "R3");
            push(5, 0, 1, 0, g, "R3");
            push(5, 0, 1, 0, g, "R3");
            push(3, 0, 0, 0, g, "R3");
            push(4, 1, 0, 1, g, "R3");
            push(4, 1, 0, 0, g, "R3");
            push(0, 0, 0, 0, g, "R2");
            push(7, 0, 0, 0, g, "R7");
        end else begin
            push(1, 0, 0, 0, 0, "R4");
            push(1, 0, 0, 0, g + 500 * CPU, "R5");
            push(4, 2, 0, 0, g, "R4");
            push(4, 3, 0, 0, g, "R4");
            push(4, 1, 0, 0, g, "R4");
            push(3, 0, 0, 0, g, "R4");
            push(6, 0, 0, 0, g + 50 * CPU, "R6");
            push(0, 0, 0, 0, g, "R4");
            push(7, 0, 0, 0, g, "R7");
        end
        push(8, 0, 0, 0, g, "R8");
        @(negedge clk);
        ddr3_i = d3; col_i = col[COL_W-1:0]; row_i = row[ROW_W-1:0];
        seq_i = sq; narrow_i = nar; start_i = 1;
        @(negedge clk);
        start_i = 0;
        // R10: scramble configuration after capture
        ddr3_i = ~d3; col_i = ~col_i; row_i = ~row_i; seq_i = ~sq; narrow_i = ~nar;
        if (disturb) begin
            repeat (30) @(negedge clk);
            check(done_o == 0, "R9", "done low while running", done_o, 0);
            start_i = 1;
            @(negedge clk);
            start_i = 0;
        end
        while (q.size() != 0) @(negedge clk);
        check(done_o == 1, "R8", "done after refresh load", done_o, 1);
        repeat (20) @(negedge clk);
        check(done_o == 1 && !cmd_valid_o, "R9", "done held", done_o, 1);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                check(0, "R7", "watchdog expired", 0, 1);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!cmd_valid_o && !done_o && !rfsh_load_o && !dll_rst_o && !ocd_dflt_o,
              "R11", "outputs in reset", {cmd_valid_o, done_o, rfsh_load_o, dll_rst_o, ocd_dflt_o}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check(!cmd_valid_o && !done_o, "R11", "idle after reset", {cmd_valid_o, done_o}, 0);
        run_seq(0, 1, 2, 1, 0, 1);   // DDR2, offset 25
        run_seq(1, 2, 3, 0, 1, 1);   // DDR3, offset 12
        run_seq(0, 0, 1, 0, 1, 0);   // DDR2 again from done, offset 10
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule